// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block picks the most urgent interrupt request for a microcontroller core and turns it into a dispatch. Requests come from one of two sources, chosen by a mode input. In pin mode, eight level-sensitive request lines are used. In external mode, a companion controller presents one interrupt number from a space of 256, together with a priority for that number. A request is accepted only when its priority is strictly above the software-set base level.

Arbitration and vector generation are separate stages. The resolver ranks the live requests and latches the winner's number and priority. A separate generator then multiplies the latched number by a programmable spacing to form a 16-bit offset from the vector base. That offset is valid while the context save is still in progress, so the core can start fetching the handler before the save handshake completes.

The context save and restore appear only as request/acknowledge pairs. When a handler ends and another request is already above the base level, the controller hands the core straight to the new handler. It skips both the restore and the save in that case.

A small companion register gives single-cycle atomic bit set and bit clear on a peripheral control word.

Top module: `vec_irq_ctrl`

## Requirements
- R1: In pin mode (ext_mode_i=0), the winning request is the highest-indexed asserted bit of pin_req_i. Its number is the bit index and its priority is the bit index plus one.
- R2: In external mode (ext_mode_i=1), pin_req_i is ignored. A request exists only while ext_valid_i is high, and it carries ext_num_i and ext_prio_i. A priority of 0 is never taken.
- R3: From idle, a request is taken only if its priority is strictly greater than base_ipl_i. While a handler runs, ipl_o equals the priority of that handler; at all other times it equals base_ipl_i.
- R4: vec_off_o equals irq_num_o multiplied by spacing_i, keeping the low 16 bits of the product.
- R5: Taking a request raises save_req_o for exactly one cycle, in the cycle after the request is sampled. pf_valid_o stays high, with irq_num_o and vec_off_o already valid, from that cycle until save_ack_i is sampled.
- R6: disp_valid_o pulses for one cycle in the cycle after save_ack_i is sampled during the save wait. It never pulses before that acknowledge.
- R7: If eoi_i is sampled while a handler runs and a request above base_ipl_i is pending, the controller chains. In the next cycle, disp_valid_o and chain_o pulse together with the new number, priority and vector, and neither save_req_o nor restore_req_o is raised. If the pending request is at or below base_ipl_i, the controller does not chain.
- R8: If eoi_i is sampled with no qualifying request, restore_req_o pulses for one cycle in the next cycle. No new request is taken until restore_ack_i has been sampled.
- R9: Each cycle, periph_o becomes (periph_o AND NOT bit_clr_i) OR bit_set_i. A bit named in both masks ends up set, and all-zero masks leave the word unchanged.
- R10: After reset, every request/valid output is low and periph_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the external-controller source |
| pin_req_i | input | 8 | Level requests on the direct pins |
| ext_valid_i | input | 1 | External request present |
| ext_num_i | input | 8 | External interrupt number |
| ext_prio_i | input | 4 | External request priority |
| base_ipl_i | input | 4 | Software base priority level |
| spacing_i | input | 16 | Vector spacing multiplier |
| eoi_i | input | 1 | Handler finished (one-cycle) |
| save_ack_i | input | 1 | Context save complete |
| restore_ack_i | input | 1 | Context restore complete |
| bit_set_i | input | 8 | Bits to set in the peripheral word |
| bit_clr_i | input | 8 | Bits to clear in the peripheral word |
| save_req_o | output | 1 | Context save request pulse |
| restore_req_o | output | 1 | Context restore request pulse |
| pf_valid_o | output | 1 | Early vector valid while the save is pending |
| disp_valid_o | output | 1 | Handler dispatch pulse |
| chain_o | output | 1 | Dispatch came from chaining |
| irq_num_o | output | 8 | Number of the selected interrupt |
| ipl_o | output | 4 | Current interrupt priority level |
| vec_off_o | output | 16 | Vector offset from the base |
| periph_o | output | 8 | Peripheral control word |

## Verification
The assertions assume that eoi_i is asserted only while a handler is running. They also assume that each acknowledge is given only while its request is outstanding, and that base_ipl_i and spacing_i stay steady through a take. The stimulus follows these rules. It always waits for the relevant pulse before raising an acknowledge or end-of-handler, and it changes the base level and spacing only while the controller is idle. Random pin patterns, base levels and spacings run through complete entry and exit sequences. Directed cases cover external numbers whose product with the spacing overflows 16 bits, priority zero, chaining both allowed and blocked, and requests raised during the restore wait.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_RUN  = 2'd2,
    ST_REST = 2'd3
  } vic_state_e;
endpackage

// File: rtl/vic_resolve.sv
module vic_resolve #(
  parameter int NPIN   = 8,
  parameter int NUM_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic              ext_mode_i,
  input  logic [NPIN-1:0]   pin_req_i,
  input  logic              ext_valid_i,
  input  logic [NUM_W-1:0]  ext_num_i,
  input  logic [PRIO_W-1:0] ext_prio_i,
  output logic              cand_valid_o,
  output logic [NUM_W-1:0]  cand_num_o,
  output logic [PRIO_W-1:0] cand_prio_o
);
  logic              pin_any;
  logic [NUM_W-1:0]  pin_num;
  logic [PRIO_W-1:0] pin_prio;

  // ascending scan: last hit is the highest index
  always_comb begin
    pin_any  = 1'b0;
    pin_num  = '0;
    pin_prio = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (pin_req_i[i]) begin
        pin_any  = 1'b1;
        pin_num  = NUM_W'(i);
        pin_prio = PRIO_W'(i + 1);
      end
    end
  end

  always_comb begin
    if (ext_mode_i) begin
      cand_valid_o = ext_valid_i && (ext_prio_i != '0);
      cand_num_o   = ext_num_i;
      cand_prio_o  = ext_prio_i;
    end else begin
      cand_valid_o = pin_any;
      cand_num_o   = pin_num;
      cand_prio_o  = pin_prio;
    end
  end
endmodule

// File: rtl/vic_vecgen.sv
module vic_vecgen #(
  parameter int NUM_W = 8,
  parameter int OFF_W = 16
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [OFF_W-1:0] spacing_i,
  output logic [OFF_W-1:0] vec_off_o
);
  localparam int PROD_W = NUM_W + OFF_W;
  logic [PROD_W-1:0] prod;

  assign prod      = PROD_W'(num_i) * PROD_W'(spacing_i);
  assign vec_off_o = prod[OFF_W-1:0];
endmodule

// File: rtl/vic_bitop.sv
module vic_bitop #(
  parameter int BIT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BIT_W-1:0] bit_set_i,
  input  logic [BIT_W-1:0] bit_clr_i,
  output logic [BIT_W-1:0] periph_o
);
  logic [BIT_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= (word_q & ~bit_clr_i) | bit_set_i;
  end

  assign periph_o = word_q;

  assert_set_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((periph_o & $past(bit_set_i)) == $past(bit_set_i)));
  assert_clr_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((periph_o & $past(bit_clr_i) & ~$past(bit_set_i)) == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int NUM_W  = 8,
  parameter int PRIO_W = 4,
  parameter int OFF_W  = 16,
  parameter int BIT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic [NPIN-1:0]   pin_req_i,
  input  logic              ext_valid_i,
  input  logic [NUM_W-1:0]  ext_num_i,
  input  logic [PRIO_W-1:0] ext_prio_i,
  input  logic [PRIO_W-1:0] base_ipl_i,
  input  logic [OFF_W-1:0]  spacing_i,
  input  logic              eoi_i,
  input  logic              save_ack_i,
  input  logic              restore_ack_i,
  input  logic [BIT_W-1:0]  bit_set_i,
  input  logic [BIT_W-1:0]  bit_clr_i,
  output logic              save_req_o,
  output logic              restore_req_o,
  output logic              pf_valid_o,
  output logic              disp_valid_o,
  output logic              chain_o,
  output logic [NUM_W-1:0]  irq_num_o,
  output logic [PRIO_W-1:0] ipl_o,
  output logic [OFF_W-1:0]  vec_off_o,
  output logic [BIT_W-1:0]  periph_o
);
  logic              cand_valid;
  logic [NUM_W-1:0]  cand_num;
  logic [PRIO_W-1:0] cand_prio;
  logic              take;

  vic_state_e        state_q;
  logic [NUM_W-1:0]  num_q;
  logic [PRIO_W-1:0] prio_q;
  logic              save_q, rest_q, disp_q, chain_q;

  vic_resolve #(.NPIN(NPIN), .NUM_W(NUM_W), .PRIO_W(PRIO_W)) u_resolve (
    .ext_mode_i  (ext_mode_i),
    .pin_req_i   (pin_req_i),
    .ext_valid_i (ext_valid_i),
    .ext_num_i   (ext_num_i),
    .ext_prio_i  (ext_prio_i),
    .cand_valid_o(cand_valid),
    .cand_num_o  (cand_num),
    .cand_prio_o (cand_prio)
  );

  assign take = cand_valid && (cand_prio > base_ipl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      num_q   <= '0;
      prio_q  <= '0;
      save_q  <= 1'b0;
      rest_q  <= 1'b0;
      disp_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      save_q  <= 1'b0;
      rest_q  <= 1'b0;
      disp_q  <= 1'b0;
      chain_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_SAVE;
          save_q  <= 1'b1;
          num_q   <= cand_num;
          prio_q  <= cand_prio;
        end
        ST_SAVE: if (save_ack_i) begin
          state_q <= ST_RUN;
          disp_q  <= 1'b1;
        end
        ST_RUN: if (eoi_i) begin
          if (take) begin
            num_q   <= cand_num;
            prio_q  <= cand_prio;
            disp_q  <= 1'b1;
            chain_q <= 1'b1;
          end else begin
            state_q <= ST_REST;
            rest_q  <= 1'b1;
          end
        end
        ST_REST: if (restore_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  vic_vecgen #(.NUM_W(NUM_W), .OFF_W(OFF_W)) u_vecgen (
    .num_i    (num_q),
    .spacing_i(spacing_i),
    .vec_off_o(vec_off_o)
  );

  vic_bitop #(.BIT_W(BIT_W)) u_bitop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_set_i(bit_set_i),
    .bit_clr_i(bit_clr_i),
    .periph_o (periph_o)
  );

  assign save_req_o    = save_q;
  assign restore_req_o = rest_q;
  assign disp_valid_o  = disp_q;
  assign chain_o       = chain_q;
  assign pf_valid_o    = (state_q == ST_SAVE);
  assign irq_num_o     = num_q;
  assign ipl_o         = (state_q == ST_RUN) ? prio_q : base_ipl_i;

  assert_take_above_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |-> ($past(cand_prio) > $past(base_ipl_i)));
  assert_save_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |=> !save_req_o);
  assert_save_opens_prefetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |-> pf_valid_o);
  assert_disp_needs_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && !chain_o) |-> ($past(save_ack_i) && $past(pf_valid_o)));
  assert_chain_skips_stack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |-> (disp_valid_o && !save_req_o && !restore_req_o));
  assert_restore_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o |=> !restore_req_o);
  assert_no_take_in_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o |=> !save_req_o);
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic [7:0]  pin_req = '0;
  logic        ext_valid = 1'b0;
  logic [7:0]  ext_num = '0;
  logic [3:0]  ext_prio = '0;
  logic [3:0]  base_ipl = '0;
  logic [15:0] spacing = 16'h0010;
  logic        eoi = 1'b0, save_ack = 1'b0, restore_ack = 1'b0;
  logic [7:0]  bit_set = '0, bit_clr = '0;
  logic        save_req, restore_req, pf_valid, disp_valid, chain;
  logic [7:0]  irq_num;
  logic [3:0]  ipl;
  logic [15:0] vec_off;
  logic [7:0]  periph;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .pin_req_i(pin_req),
    .ext_valid_i(ext_valid), .ext_num_i(ext_num), .ext_prio_i(ext_prio),
    .base_ipl_i(base_ipl), .spacing_i(spacing), .eoi_i(eoi),
    .save_ack_i(save_ack), .restore_ack_i(restore_ack),
    .bit_set_i(bit_set), .bit_clr_i(bit_clr),
    .save_req_o(save_req), .restore_req_o(restore_req), .pf_valid_o(pf_valid),
    .disp_valid_o(disp_valid), .chain_o(chain), .irq_num_o(irq_num),
    .ipl_o(ipl), .vec_off_o(vec_off), .periph_o(periph)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [7:0] n, input logic [15:0] sp);
    logic [23:0] p;
    p = {16'h0, n} * {8'h0, sp};
    return p[15:0];
  endfunction

  function automatic int top_pin(input logic [7:0] p);
    int r;
    r = -1;
    for (int i = 0; i < 8; i++) if (p[i]) r = i;
    return r;
  endfunction

  // call at the negedge where the request is already driven
  task automatic enter(input logic [7:0] n, input logic [3:0] pr);
    @(negedge clk);
    chk("R5 save_req", save_req, 1);
    chk("R5 pf_valid", pf_valid, 1);
    chk("R1/R2 irq_num", irq_num, n);
    chk("R4 vec_off", vec_off, exp_vec(n, spacing));
    chk("R6 no early disp", disp_valid, 0);
    @(negedge clk);
    chk("R5 save_req single", save_req, 0);
    chk("R6 wait for ack", disp_valid, 0);
    chk("R5 pf_valid held", pf_valid, 1);
    save_ack = 1'b1;
    @(negedge clk);
    save_ack = 1'b0;
    chk("R6 disp", disp_valid, 1);
    chk("R7 not chained", chain, 0);
    chk("R3 ipl raised", ipl, pr);
  endtask

  task automatic leave();
    pin_req = '0;
    ext_valid = 1'b0;
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk("R8 restore_req", restore_req, 1);
    chk("R8 no disp", disp_valid, 0);
    restore_ack = 1'b1;
    @(negedge clk);
    restore_ack = 1'b0;
    chk("R3 ipl back to base", ipl, base_ipl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog all requirements act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] model;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R10 save_req", save_req, 0);
    chk("R10 disp", disp_valid, 0);
    chk("R10 restore", restore_req, 0);
    chk("R10 periph", periph, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed pin entry/exit
    spacing = 16'h0020;
    pin_req = 8'b0100_1010;
    enter(8'd6, 4'd7);
    pin_req = '0;
    leave();

    // random pin patterns
    for (int it = 0; it < 40; it++) begin
      logic [7:0] p;
      int w;
      p = 8'($urandom_range(1, 255));
      w = top_pin(p);
      base_ipl = 4'($urandom_range(0, 8));
      spacing = 16'($urandom);
      pin_req = p;
      if (4'(w + 1) > base_ipl) begin
        enter(8'(w), 4'(w + 1));
        pin_req = '0;
        leave();
      end else begin
        @(negedge clk);
        chk("R3 below base not taken", save_req, 0);
        chk("R3 ipl stays base", ipl, base_ipl);
        pin_req = '0;
        @(negedge clk);
      end
    end

    // chaining allowed
    base_ipl = 4'd0;
    spacing = 16'h0040;
    pin_req = 8'b0000_1000;
    enter(8'd3, 4'd4);
    pin_req = 8'b0010_0000;
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk("R7 chain disp", disp_valid, 1);
    chk("R7 chain flag", chain, 1);
    chk("R7 chain num", irq_num, 5);
    chk("R7 chain ipl", ipl, 6);
    chk("R7 chain vec", vec_off, exp_vec(8'd5, spacing));
    chk("R7 no save", save_req, 0);
    chk("R7 no restore", restore_req, 0);
    pin_req = '0;
    leave();

    // chaining blocked by base level
    base_ipl = 4'd4;
    pin_req = 8'b0100_0000;
    enter(8'd6, 4'd7);
    pin_req = 8'b0000_0100;
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk("R7 blocked chain restores", restore_req, 1);
    chk("R7 blocked no disp", disp_valid, 0);
    pin_req = 8'b1000_0000;
    repeat (2) begin
      @(negedge clk);
      chk("R8 no take during restore", save_req, 0);
    end
    restore_ack = 1'b1;
    @(negedge clk);
    restore_ack = 1'b0;
    chk("R8 still idle", save_req, 0);
    enter(8'd7, 4'd8);
    pin_req = '0;
    leave();

    // external mode
    ext_mode = 1'b1;
    base_ipl = 4'd2;
    spacing = 16'h0100;
    pin_req = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R2 pins ignored", save_req, 0);
    ext_valid = 1'b1; ext_num = 8'd200; ext_prio = 4'd9;
    enter(8'd200, 4'd9);
    leave();
    spacing = 16'h0400;
    ext_valid = 1'b1; ext_num = 8'd255; ext_prio = 4'd15;
    enter(8'd255, 4'd15);
    chk("R4 vec wraps", vec_off, 16'hFC00);
    leave();
    base_ipl = 4'd0;
    ext_valid = 1'b1; ext_num = 8'd17; ext_prio = 4'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 prio zero ignored", save_req, 0);
    chk("R2 prio zero no prefetch", pf_valid, 0);
    ext_valid = 1'b0;
    ext_mode = 1'b0;

    // atomic bit operations
    model = periph;
    bit_set = 8'h3C; bit_clr = 8'h00;
    @(negedge clk);
    model = (model & ~8'h00) | 8'h3C;
    chk("R9 set", periph, model);
    bit_set = 8'h04; bit_clr = 8'h0C;
    @(negedge clk);
    model = (model & ~8'h0C) | 8'h04;
    chk("R9 set wins", periph, model);
    bit_set = 8'h00; bit_clr = 8'h00;
    @(negedge clk);
    chk("R9 zero masks hold", periph, model);
    for (int it = 0; it < 30; it++) begin
      logic [7:0] s, c;
      s = 8'($urandom);
      c = 8'($urandom);
      bit_set = s & 8'($urandom);
      bit_clr = c;
      @(negedge clk);
      model = (model & ~c) | (s & bit_set);
      chk("R9 random rmw", periph, model);
    end
    bit_set = '0; bit_clr = '0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule